// File: doc/BRIEF.md
# External Bus Page-Access Sequencer

This block converts one internal bus request into a train of timed external memory beats. Every beat in the train shares a single chip-select assertion, so page-mode memories can run several accesses back to back. A request carries a base address, a direction, a beat count and four wait settings. All of these are captured when the request is accepted. The external address then steps by four bytes on each beat.

The first beat pays the full access wait. Each later beat uses a shorter page wait. Between beats, the read or write strobe can be pulsed high by a programmable gap. For writes, an extra data-delay phase can be inserted before each later beat, with the data bus released during that phase. A write ends with one chip-select delay cycle. A read releases chip select straight after its last beat. A one-cycle completion pulse marks the first cycle in which chip select is high again.

Write data for later beats is supplied through a simple handshake. The block flags the cycle in which it will take the next word. Read data is captured at the end of each beat and presented one cycle later.

Top module: `page_bus_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_ready` is high. The cycle after acceptance is a start cycle in which `ext_cs_n`, `ext_rd_n` and `ext_wr_n` are all high and `req_ready` is low.
- R2: The base address, and for writes the first data word, appear on `ext_addr`/`ext_wdata` in the cycle after the start cycle. Beat k (k counting from 0) drives address base + 4·k.
- R3: The first beat keeps its strobe low for max(access wait, 1) cycles. The last of these cycles is the beat's end cycle.
- R4: Each later beat keeps its strobe low for max(page wait, 1) cycles.
- R5: In a write, a nonzero data-delay setting d inserts d cycles before the strobe-low part of each later beat. In these cycles the strobe is high, chip select is low and `ext_oe` is low. For reads the setting has no effect.
- R6: A nonzero strobe-gap setting g holds the strobe high for g cycles right after each end cycle that is followed by another beat. With g = 0 (and no data delay), the strobe stays low from beat to beat.
- R7: `ext_cs_n` stays low, without a break, from the first beat's first cycle to the last beat's end cycle. Neither strobe is ever low while chip select is high, and the two strobes are never low together.
- R8: After the last write beat, one extra cycle follows with chip select low and the strobe high. After the last read beat, chip select rises in the next cycle.
- R9: `done` is high for exactly one cycle: the first cycle with `ext_cs_n` high after the page. `req_ready` is high in the following cycle.
- R10: `ext_rdata` is captured at the clock edge that ends each read beat's end cycle. It is presented on `rd_data` with `rd_valid` high in the next cycle, giving one pulse per beat. The next beat starts with no extra sample cycle.
- R11: Settings and beat count are sampled at acceptance, and later changes have no effect. A beat count of 0 runs one beat, and a count above 8 runs 8 beats.
- R12: `wdata_next` is high in the end cycle of each write beat that has a successor. The value on `wdata_in` at that cycle's closing edge becomes the next beat's data. The first beat's data is taken at the start cycle's closing edge.
- R13: While reset is low, the block sits idle: chip select and both strobes are high, `ext_oe`, `done` and `rd_valid` are low, and `req_ready` is high. This holds even when reset arrives in the middle of a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_write | input | 1 | 1 = write page, 0 = read page |
| req_addr | input | AW | Base byte address |
| req_beats | input | BCW | Requested beat count |
| cfg_acc_wait | input | WW | First-beat access wait |
| cfg_page_wait | input | WW | Later-beat page wait |
| cfg_wdata_dly | input | WW | Write data-delay cycles before later beats |
| cfg_strb_gap | input | WW | Strobe-high cycles between beats |
| wdata_in | input | DW | Write data source |
| wdata_next | output | 1 | Next beat's data taken at this cycle's end |
| ext_addr | output | AW | External address |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_wdata | output | DW | External write data |
| ext_oe | output | 1 | Write data output enable |
| ext_rdata | input | DW | External read data |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | rd_data valid pulse |
| done | output | 1 | Page completion pulse |

## Verification
The bound checker watches the per-cycle relationships on every cycle:
- the start cycle after acceptance,
- strobes only under chip select and never both low,
- the data enable only with the write strobe,
- the handshake and read-valid only after a strobe-low cycle,
- the rise of chip select only into the completion pulse, followed by ready.

Cycle counts depend on the wait settings and on the beat count, so only the bench's scenarios can show them. These include:
- the chip-select length, the strobe-low and strobe-gap totals,
- the address and data of each beat,
- the read values, and sampling at acceptance,
- the clamping of the beat count, and recovery from reset mid-page.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_WAIT,
      ST_END,
      ST_GAP,
      ST_DLY,
      ST_CSD,
      ST_DONE
   } pg_state_e;
endpackage

// File: rtl/pgseq_cnt.sv
module pgseq_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         last
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pgseq_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= ld_val;
      else if (dec && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign last = (cnt <= W'(1));
endmodule

// File: rtl/pgseq_addr.sv
module pgseq_addr #(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_val,
   input  logic          inc,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   generate
      if (STEP < 1) begin : g_bad_step
         $error("pgseq_addr: STEP must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= ld_val;
      else if (inc)
         addr <= addr + STEP_V;
   end
endmodule

// File: rtl/page_bus_seq.sv
module page_bus_seq
   import pgseq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int WW        = 4,
   parameter int MAX_BEATS = 8,
   parameter int ADDR_STEP = 4,
   localparam int BCW      = $clog2(MAX_BEATS) + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [BCW-1:0] req_beats,
   input  logic [WW-1:0]  cfg_acc_wait,
   input  logic [WW-1:0]  cfg_page_wait,
   input  logic [WW-1:0]  cfg_wdata_dly,
   input  logic [WW-1:0]  cfg_strb_gap,
   input  logic [DW-1:0]  wdata_in,
   output logic           wdata_next,
   output logic [AW-1:0]  ext_addr,
   output logic           ext_cs_n,
   output logic           ext_rd_n,
   output logic           ext_wr_n,
   output logic [DW-1:0]  ext_wdata,
   output logic           ext_oe,
   input  logic [DW-1:0]  ext_rdata,
   output logic [DW-1:0]  rd_data,
   output logic           rd_valid,
   output logic           done
);
   localparam logic [BCW-1:0] MAXB_V = BCW'(MAX_BEATS);

   generate
      if (AW < 3 || DW < 1 || WW < 1 || MAX_BEATS < 1) begin : g_bad_cfg
         $error("page_bus_seq: illegal parameter set");
      end
   endgenerate

   pg_state_e      state, nxt;
   logic           s_wr;
   logic [AW-1:0]  s_addr;
   logic [BCW-1:0] s_beats;
   logic [WW-1:0]  s_acc, s_pw, s_dly, s_sw;
   logic           take;

   logic           c_ld, c_dec, c_last;
   logic [WW-1:0]  c_val, c_cnt;
   logic           b_ld, b_dec, b_last_unused;
   logic [BCW-1:0] b_cnt;
   logic           a_ld, a_inc, w_ld;
   logic           strb;

   // picks the first phase of a following beat
   function automatic pg_state_e route(input logic use_gap, input logic use_dly,
                                       input logic wr, input logic [WW-1:0] sw,
                                       input logic [WW-1:0] dly, input logic [WW-1:0] pw);
      if (use_gap && sw != '0)
         return ST_GAP;
      else if (use_dly && wr && dly != '0)
         return ST_DLY;
      else if (pw > WW'(1))
         return ST_WAIT;
      else
         return ST_END;
   endfunction

   always_comb begin
      nxt   = state;
      take  = 1'b0;
      a_ld  = 1'b0;
      a_inc = 1'b0;
      w_ld  = 1'b0;
      b_ld  = 1'b0;
      b_dec = 1'b0;
      unique case (state)
         ST_IDLE:  if (req_valid) begin
                      nxt  = ST_START;
                      take = 1'b1;
                   end
         ST_START: begin
                      a_ld = 1'b1;
                      w_ld = s_wr;
                      b_ld = 1'b1;
                      nxt  = (s_acc > WW'(1)) ? ST_WAIT : ST_END;
                   end
         ST_WAIT:  if (c_last) nxt = ST_END;
         ST_END:   if (b_cnt == '0) begin
                      nxt = s_wr ? ST_CSD : ST_DONE;
                   end else begin
                      a_inc = 1'b1;
                      w_ld  = s_wr;
                      b_dec = 1'b1;
                      nxt   = route(1'b1, 1'b1, s_wr, s_sw, s_dly, s_pw);
                   end
         ST_GAP:   if (c_last) nxt = route(1'b0, 1'b1, s_wr, s_sw, s_dly, s_pw);
         ST_DLY:   if (c_last) nxt = route(1'b0, 1'b0, s_wr, s_sw, s_dly, s_pw);
         ST_CSD:   nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   // wait counter control: load on entry to a timed phase, count down while staying
   always_comb begin
      c_ld  = (nxt != state) && (nxt inside {ST_WAIT, ST_GAP, ST_DLY});
      c_dec = (nxt == state) && (state inside {ST_WAIT, ST_GAP, ST_DLY});
      if (state == ST_START)
         c_val = s_acc - 1'b1;
      else begin
         unique case (nxt)
            ST_GAP:  c_val = s_sw;
            ST_DLY:  c_val = s_dly;
            default: c_val = s_pw - 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         s_wr    <= 1'b0;
         s_addr  <= '0;
         s_beats <= BCW'(1);
         s_acc   <= '0;
         s_pw    <= '0;
         s_dly   <= '0;
         s_sw    <= '0;
      end else begin
         state <= nxt;
         if (take) begin
            s_wr   <= req_write;
            s_addr <= req_addr;
            s_acc  <= cfg_acc_wait;
            s_pw   <= cfg_page_wait;
            s_dly  <= cfg_wdata_dly;
            s_sw   <= cfg_strb_gap;
            if (req_beats == '0)
               s_beats <= BCW'(1);
            else if (req_beats > MAXB_V)
               s_beats <= MAXB_V;
            else
               s_beats <= req_beats;
         end
      end
   end

   pgseq_cnt #(.W(WW)) wait_cnt_i (
      .clk(clk), .rst_n(rst_n), .load(c_ld), .ld_val(c_val),
      .dec(c_dec), .cnt(c_cnt), .last(c_last)
   );

   pgseq_cnt #(.W(BCW)) beat_cnt_i (
      .clk(clk), .rst_n(rst_n), .load(b_ld), .ld_val(s_beats - 1'b1),
      .dec(b_dec), .cnt(b_cnt), .last(b_last_unused)
   );

   pgseq_addr #(.AW(AW), .STEP(ADDR_STEP)) addr_i (
      .clk(clk), .rst_n(rst_n), .load(a_ld), .ld_val(s_addr),
      .inc(a_inc), .addr(ext_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_wdata <= '0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
      end else begin
         if (w_ld)
            ext_wdata <= wdata_in;
         rd_valid <= (state == ST_END) && !s_wr;
         if (state == ST_END && !s_wr)
            rd_data <= ext_rdata;
      end
   end

   assign strb       = (state == ST_WAIT) || (state == ST_END);
   assign ext_cs_n   = !(state inside {ST_WAIT, ST_END, ST_GAP, ST_DLY, ST_CSD});
   assign ext_rd_n   = !(strb && !s_wr);
   assign ext_wr_n   = !(strb && s_wr);
   assign ext_oe     = strb && s_wr;
   assign wdata_next = s_wr && (state == ST_END) && (b_cnt != '0);
   assign done       = (state == ST_DONE);
   assign req_ready  = (state == ST_IDLE);
endmodule

// File: rtl/page_bus_seq_chk.sv
module page_bus_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic ext_cs_n,
   input logic ext_rd_n,
   input logic ext_wr_n,
   input logic ext_oe,
   input logic rd_valid,
   input logic wdata_next,
   input logic done
);
   // R1
   start_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ext_cs_n && ext_rd_n && ext_wr_n && !req_ready));

   // R7
   strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n || !ext_wr_n) |-> !ext_cs_n);

   // R7
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_rd_n && !ext_wr_n));

   // R5
   oe_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_oe |-> !ext_wr_n);

   // R9
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_cs_n) |-> done);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   // R10
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!ext_rd_n));

   // R12
   wnext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_next |-> (!ext_wr_n && !ext_cs_n));
endmodule

bind page_bus_seq page_bus_seq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
   .ext_oe(ext_oe), .rd_valid(rd_valid), .wdata_next(wdata_next), .done(done)
);

// File: tb/page_bus_seq_tb_top.sv
module page_bus_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_write;
   logic [31:0] req_addr;
   logic [3:0]  req_beats;
   logic [3:0]  cfg_acc_wait, cfg_page_wait, cfg_wdata_dly, cfg_strb_gap;
   logic [31:0] wdata_in, ext_addr, ext_wdata, ext_rdata, rd_data;
   logic        wdata_next, ext_cs_n, ext_rd_n, ext_wr_n, ext_oe, rd_valid, done;
   int          n_chk = 0;
   int          n_bad = 0;

   always #5 clk = ~clk;
   assign ext_rdata = ~ext_addr;

   page_bus_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_beats(req_beats),
      .cfg_acc_wait(cfg_acc_wait), .cfg_page_wait(cfg_page_wait),
      .cfg_wdata_dly(cfg_wdata_dly), .cfg_strb_gap(cfg_strb_gap),
      .wdata_in(wdata_in), .wdata_next(wdata_next), .ext_addr(ext_addr),
      .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
      .ext_wdata(ext_wdata), .ext_oe(ext_oe), .ext_rdata(ext_rdata),
      .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
   );

   // {wr, beats, acc, pw, dly, gap, cs_low_cycles, strobe_low_cycles, strobe_rises_under_cs}
   localparam logic [44:0] VEC [8] = '{
      {1'b1, 4'd1,  4'd0, 4'd0, 4'd0, 4'd0, 8'd2,  8'd1,  8'd1},
      {1'b1, 4'd4,  4'd3, 4'd1, 4'd0, 4'd0, 8'd7,  8'd6,  8'd1},
      {1'b1, 4'd3,  4'd2, 4'd2, 4'd1, 4'd1, 8'd11, 8'd6,  8'd3},
      {1'b0, 4'd2,  4'd4, 4'd0, 4'd5, 4'd0, 8'd5,  8'd5,  8'd0},
      {1'b0, 4'd8,  4'd1, 4'd2, 4'd0, 4'd2, 8'd29, 8'd15, 8'd7},
      {1'b1, 4'd2,  4'd1, 4'd0, 4'd2, 4'd0, 8'd5,  8'd2,  8'd2},
      {1'b0, 4'd0,  4'd2, 4'd3, 4'd0, 4'd0, 8'd2,  8'd2,  8'd0},
      {1'b1, 4'd12, 4'd0, 4'd0, 4'd0, 4'd0, 8'd9,  8'd8,  8'd1}
   };

   function automatic logic [31:0] wd(input int v, input int k);
      return 32'hA500_0000 ^ (32'(v) << 8) ^ 32'(k);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input int v, input logic [44:0] e);
      logic        wr;
      logic [3:0]  beats;
      int          neff, ncs, nst, nrise, kb, nrd, badw, badr;
      logic [31:0] base;
      bit          pcs, psl, csl, sl, fin;
      wr    = e[44];
      beats = e[43:40];
      neff  = (beats == 0) ? 1 : (beats > 8) ? 8 : int'(beats);
      base  = 32'h1000_0000 + 32'(v) * 32'h100;
      ncs = 0; nst = 0; nrise = 0; kb = 0; nrd = 0; badw = 0; badr = 0;
      pcs = 0; psl = 0; fin = 0;
      @(negedge clk);
      req_write     = wr;
      req_beats     = beats;
      req_addr      = base;
      cfg_acc_wait  = e[39:36];
      cfg_page_wait = e[35:32];
      cfg_wdata_dly = e[31:28];
      cfg_strb_gap  = e[27:24];
      wdata_in      = wd(v, 0);
      req_valid     = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // R11: disturb every sampled input after acceptance
      cfg_acc_wait = 4'hF; cfg_page_wait = 4'hF; cfg_wdata_dly = 4'hF; cfg_strb_gap = 4'hF;
      req_beats = 4'd7; req_addr = 32'hDEAD_0000; req_write = ~wr;
      chk(ext_cs_n && ext_rd_n && ext_wr_n && !req_ready, "R1 start cycle",
          {28'd0, ext_cs_n, ext_rd_n, ext_wr_n, req_ready}, 32'hE);
      for (int c = 2; c < 300 && !fin; c++) begin
         @(negedge clk);
         if (c == 2) begin
            chk(ext_addr == base, "R2 first address", ext_addr, base);
            if (wr) chk(ext_wdata == wd(v, 0), "R2 first data", ext_wdata, wd(v, 0));
         end
         csl = !ext_cs_n;
         sl  = !ext_rd_n || !ext_wr_n;
         if (csl) ncs++;
         if (sl) nst++;
         if (psl && !sl && csl) nrise++;
         if (!ext_wr_n && (ext_addr != base + 32'(4 * kb) || ext_wdata != wd(v, kb) || !ext_oe))
            badw++;
         if (wdata_next) begin
            kb++;
            wdata_in = wd(v, kb);
         end
         if (rd_valid) begin
            if (rd_data != ~(base + 32'(4 * nrd))) badr++;
            nrd++;
         end
         if (pcs && !csl) begin
            chk(done == 1'b1, "R9 done at cs release", 32'(done), 32'd1);
            if (wr) chk(!psl, "R8 write cs delay cycle", 32'(psl), 32'd0);
            else    chk(psl, "R8 read direct release", 32'(psl), 32'd1);
            fin = 1;
         end
         pcs = csl;
         psl = sl;
      end
      chk(ncs == int'(e[23:16]), "R7 cs low length (R3 R4 R5 R6)", 32'(ncs), 32'(e[23:16]));
      chk(nst == int'(e[15:8]), "R3 R4 strobe low cycles", 32'(nst), 32'(e[15:8]));
      chk(nrise == int'(e[7:0]), "R6 strobe rises under cs", 32'(nrise), 32'(e[7:0]));
      if (wr) begin
         chk(kb == neff - 1, "R12 next-data requests (R11 beats)", 32'(kb), 32'(neff - 1));
         chk(badw == 0, "R2 R12 write beat addr/data", 32'(badw), 32'd0);
      end else begin
         chk(nrd == neff, "R10 read beats (R11 beats)", 32'(nrd), 32'(neff));
         chk(badr == 0, "R10 R2 read data", 32'(badr), 32'd0);
      end
      @(negedge clk);
      chk(!done && req_ready, "R9 done one cycle then ready", {30'd0, done, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_beats = '0;
      cfg_acc_wait = '0; cfg_page_wait = '0; cfg_wdata_dly = '0; cfg_strb_gap = '0;
      wdata_in = '0;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(ext_cs_n && ext_rd_n && ext_wr_n && !ext_oe && !done && !rd_valid && req_ready,
          "R13 reset idle", {25'd0, ext_cs_n, ext_rd_n, ext_wr_n, ext_oe, done, rd_valid, req_ready},
          32'h71);
      rst_n = 1'b1;
      for (int v = 0; v < 8; v++) run_vec(v, VEC[v]);

      // R13 reset in the middle of a long write page
      @(negedge clk);
      req_write = 1'b1; req_beats = 4'd8; req_addr = 32'h2000_0000;
      cfg_acc_wait = 4'd5; cfg_page_wait = 4'd3; cfg_wdata_dly = 4'd0; cfg_strb_gap = 4'd0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(!ext_cs_n && !ext_wr_n, "R7 mid-page cs and strobe low", {30'd0, ext_cs_n, ext_wr_n}, 32'd0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(ext_cs_n && ext_rd_n && ext_wr_n && !ext_oe && !done && req_ready,
          "R13 reset mid-page", {26'd0, ext_cs_n, ext_rd_n, ext_wr_n, ext_oe, done, req_ready},
          32'h39);
      rst_n = 1'b1;
      // recovery after the aborted page
      run_vec(2, VEC[2]);
      run_vec(4, VEC[4]);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule